// File: doc/BRIEF.md
# Cell Array Scan Controller

This controller walks a two-dimensional array of delay-measurement cells one cell at a time so that an external error accumulator and clock sweeper can build a timing signature for every cell. For the addressed cell it raises exactly one row enable and one column enable. It pulses a sweep request, then waits until the sweep engine reports that the full frequency sweep is finished before it moves on. The error outputs of all cells are merged into one flag. Each unselected cell is forced to zero before the merge, so the flag reflects only the cell under measurement.

The cell order is column first within a row, then the next row. When the last cell of the array has been swept, the address wraps to zero and the binary challenge applied to all cells steps up by one, and the whole array is scanned again. After the last cell under the last challenge, the controller parks in a finished state until it is told to start over. The default array is 32 by 32 cells with a 5-bit challenge, which gives 32 delay settings per element.

Top module: `cell_scan_ctrl`

## Requirements
- R1: After reset, no sweep is requested, all row and column enables are zero, `scan_done` is low, and row, column and challenge all read zero.
- R2: A `start` pulse while idle leads to `sweep_req` being high in the cycle after the edge that samples `start`, with row 0, column 0 and challenge 0.
- R3: `sweep_req` is high for exactly one cycle per cell per challenge.
- R4: While a sweep is requested or in progress, exactly one bit of `row_en` (bit `row_idx`) and one bit of `col_en` (bit `col_idx`) is set. In every other state both vectors are all zero.
- R5: Row, column and challenge stay unchanged from the sweep request until `sweep_done` is accepted.
- R6: When a sweep completes, the column advances by one. After the last column it wraps to 0 and the row advances by one. The next `sweep_req` comes two cycles after the edge that samples `sweep_done`.
- R7: When the sweep of the last cell (last row, last column) completes and more challenges remain, row and column return to 0 and the challenge increments by one.
- R8: When the last cell has been swept under challenge `NUM_CHAL-1`, `scan_done` rises and stays high, and no further sweep is requested until a new `start`.
- R9: `err_any` equals the error bit of the selected cell, where cell (r,c) drives `cell_err` bit r*COLS+c. Errors from unselected cells have no effect on `err_any`.
- R10: `sweep_done` is ignored unless a sweep is in progress, and `start` is ignored while a scan is running.
- R11: A `start` pulse while `scan_done` is high clears `scan_done` and begins a new scan at row 0, column 0, challenge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a full scan when idle or finished |
| sweep_done | input | 1 | Sweep engine reports the current sweep finished |
| cell_err | input | ROWS*COLS | Error output of each cell, bit r*COLS+c |
| sweep_req | output | 1 | One-cycle request to run a frequency sweep |
| row_en | output | ROWS | One-hot row enable |
| col_en | output | COLS | One-hot column enable |
| row_idx | output | clog2(ROWS) | Current row address |
| col_idx | output | clog2(COLS) | Current column address |
| challenge | output | CHAL_W | Binary challenge applied to the cells |
| err_any | output | 1 | Merged error flag of the selected cell |
| scan_done | output | 1 | All cells under all challenges have been swept |

## Verification
A wrong sequencing state shows up at the ports by the next sweep request. A skipped or repeated cell appears as a wrong row, column or challenge in the same cycle that `sweep_req` rises, no later than two cycles after `sweep_done`. A corrupted enable decoder shows as a second set bit, or as an enable outside a sweep. A broken mask shows immediately as `err_any` following a cell that is not addressed. A wrong wrap or termination shows at the last cell of a challenge, either as a missing challenge step or as `scan_done` arriving early or never.

// File: rtl/cell_scan_pkg.sv
package cell_scan_pkg;

   typedef enum logic [2:0] {
      SC_IDLE   = 3'd0,
      SC_LAUNCH = 3'd1,
      SC_WAIT   = 3'd2,
      SC_STEP   = 3'd3,
      SC_DONE   = 3'd4
   } scan_state_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
   parameter int N = 32,
   parameter int W = cell_scan_pkg::idx_width(N)
) (
   input  logic [W-1:0] idx,
   input  logic         en,
   output logic [N-1:0] sel
);
   initial begin
      assert (N >= 1) else $error("onehot_dec: N must be at least 1");
      assert (W >= cell_scan_pkg::idx_width(N)) else $error("onehot_dec: W too narrow");
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      assign sel[i] = en && (idx == W'(i));
   end
endmodule

// File: rtl/scan_addr_counter.sv
module scan_addr_counter #(
   parameter int ROWS     = 32,
   parameter int COLS     = 32,
   parameter int CHAL_W   = 5,
   parameter int NUM_CHAL = 2 ** CHAL_W,
   localparam int ROW_W   = cell_scan_pkg::idx_width(ROWS),
   localparam int COL_W   = cell_scan_pkg::idx_width(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic [CHAL_W-1:0] chal,
   output logic              last_all
);
   localparam logic [ROW_W-1:0]  ROW_MAX  = ROW_W'(ROWS - 1);
   localparam logic [COL_W-1:0]  COL_MAX  = COL_W'(COLS - 1);
   localparam logic [CHAL_W-1:0] CHAL_MAX = CHAL_W'(NUM_CHAL - 1);

   logic col_last, row_last, chal_last;

   assign col_last  = (col == COL_MAX);
   assign row_last  = (row == ROW_MAX);
   assign chal_last = (chal == CHAL_MAX);
   assign last_all  = col_last && row_last && chal_last;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         row  <= '0;
         col  <= '0;
         chal <= '0;
      end else if (advance) begin
         if (!col_last) begin
            col <= col + COL_W'(1);
         end else begin
            col <= '0;
            if (!row_last) begin
               row <= row + ROW_W'(1);
            end else begin
               row <= '0;
               chal <= chal_last ? '0 : chal + CHAL_W'(1);
            end
         end
      end
   end

   // R6: column steps inside a row
   assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && !col_last) |=> (col == $past(col) + COL_W'(1)) && $stable(row) && $stable(chal));

   // R6: row steps after the last column
   assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && col_last && !row_last) |=> (col == '0) && (row == $past(row) + ROW_W'(1)) && $stable(chal));

   // R7: challenge steps after the last cell
   assert_chal_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && col_last && row_last && !chal_last) |=>
         (col == '0) && (row == '0) && (chal == $past(chal) + CHAL_W'(1)));

   // R5: no movement without a step request
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(row) && $stable(col) && $stable(chal));
endmodule

// File: rtl/err_combiner.sv
module err_combiner #(
   parameter int ROWS = 32,
   parameter int COLS = 32,
   parameter bit MASK = 1'b1
) (
   input  logic [ROWS*COLS-1:0] cell_err,
   input  logic [ROWS-1:0]      row_en,
   input  logic [COLS-1:0]      col_en,
   output logic                 err_any
);
   logic [ROWS*COLS-1:0] gated;

   if (MASK) begin : g_masked
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         for (genvar c = 0; c < COLS; c++) begin : g_col
            assign gated[r*COLS+c] = cell_err[r*COLS+c] & row_en[r] & col_en[c];
         end
      end
   end else begin : g_plain
      assign gated = cell_err;
   end

   assign err_any = |gated;
endmodule

// File: rtl/cell_scan_ctrl.sv
module cell_scan_ctrl #(
   parameter int ROWS     = 32,
   parameter int COLS     = 32,
   parameter int CHAL_W   = 5,
   parameter int NUM_CHAL = 2 ** CHAL_W,
   parameter bit MASK     = 1'b1,
   localparam int ROW_W   = cell_scan_pkg::idx_width(ROWS),
   localparam int COL_W   = cell_scan_pkg::idx_width(COLS),
   localparam int CELLS   = ROWS * COLS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sweep_done,
   input  logic [CELLS-1:0]  cell_err,
   output logic              sweep_req,
   output logic [ROWS-1:0]   row_en,
   output logic [COLS-1:0]   col_en,
   output logic [ROW_W-1:0]  row_idx,
   output logic [COL_W-1:0]  col_idx,
   output logic [CHAL_W-1:0] challenge,
   output logic              err_any,
   output logic              scan_done
);
   import cell_scan_pkg::*;

   initial begin
      assert (ROWS >= 1 && COLS >= 1) else $error("cell_scan_ctrl: empty array");
      assert (CHAL_W >= 1) else $error("cell_scan_ctrl: CHAL_W must be positive");
      assert (NUM_CHAL >= 1 && NUM_CHAL <= 2 ** CHAL_W)
         else $error("cell_scan_ctrl: NUM_CHAL out of range");
   end

   scan_state_t state, state_nx;
   logic        clear, advance, last_all, selecting;

   always_comb begin
      state_nx = state;
      unique case (state)
         SC_IDLE:   if (start) state_nx = SC_LAUNCH;
         SC_LAUNCH: state_nx = SC_WAIT;
         SC_WAIT:   if (sweep_done) state_nx = SC_STEP;
         SC_STEP:   state_nx = last_all ? SC_DONE : SC_LAUNCH;
         SC_DONE:   if (start) state_nx = SC_LAUNCH;
         default:   state_nx = SC_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SC_IDLE;
      else        state <= state_nx;
   end

   assign clear     = ((state == SC_IDLE) || (state == SC_DONE)) && start;
   assign advance   = (state == SC_STEP);
   assign selecting = (state == SC_LAUNCH) || (state == SC_WAIT);
   assign sweep_req = (state == SC_LAUNCH);
   assign scan_done = (state == SC_DONE);

   scan_addr_counter #(
      .ROWS(ROWS), .COLS(COLS), .CHAL_W(CHAL_W), .NUM_CHAL(NUM_CHAL)
   ) i_counter (
      .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
      .row(row_idx), .col(col_idx), .chal(challenge), .last_all(last_all)
   );

   onehot_dec #(.N(ROWS), .W(ROW_W)) i_row_dec (
      .idx(row_idx), .en(selecting), .sel(row_en)
   );

   onehot_dec #(.N(COLS), .W(COL_W)) i_col_dec (
      .idx(col_idx), .en(selecting), .sel(col_en)
   );

   err_combiner #(.ROWS(ROWS), .COLS(COLS), .MASK(MASK)) i_err (
      .cell_err(cell_err), .row_en(row_en), .col_en(col_en), .err_any(err_any)
   );

   // R3: sweep request lasts one cycle
   assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_req |=> !sweep_req);

   // R4: one row and one column together, or none at all
   assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (row_en != '0 || col_en != '0) |-> ($countones(row_en) == 1) && ($countones(col_en) == 1));

   // R4: enables idle outside a sweep
   assert_idle_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done || (state == SC_STEP)) |-> (row_en == '0) && (col_en == '0));

   // R5: address held while waiting on the sweep engine
   assert_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_WAIT && !sweep_done) |=> $stable(row_idx) && $stable(col_idx) && $stable(challenge));

   // R8: finished state holds without a new start
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && !start) |=> scan_done && !sweep_req);

   // R10: start while busy does not restart
   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_WAIT && start && !sweep_done) |=> (state == SC_WAIT));

   // R9: no merged error without a selected cell
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (MASK && !selecting) |-> !err_any);
endmodule

// File: tb/test_cell_scan_ctrl.sv
module test_cell_scan_ctrl;
   localparam int ROWS = 4;
   localparam int COLS = 3;
   localparam int CHAL_W = 5;
   localparam int NUM_CHAL = 3;
   localparam int CELLS = ROWS * COLS;
   localparam int RW = 2;
   localparam int CW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sweep_done = 1'b0;
   logic [CELLS-1:0] cell_err = '0;
   logic sweep_req, err_any, scan_done;
   logic [ROWS-1:0] row_en;
   logic [COLS-1:0] col_en;
   logic [RW-1:0] row_idx;
   logic [CW-1:0] col_idx;
   logic [CHAL_W-1:0] challenge;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cell_scan_ctrl #(
      .ROWS(ROWS), .COLS(COLS), .CHAL_W(CHAL_W), .NUM_CHAL(NUM_CHAL), .MASK(1'b1)
   ) i_cell_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .sweep_done(sweep_done),
      .cell_err(cell_err), .sweep_req(sweep_req), .row_en(row_en), .col_en(col_en),
      .row_idx(row_idx), .col_idx(col_idx), .challenge(challenge),
      .err_any(err_any), .scan_done(scan_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_en(input int pos);
      return 1 << pos;
   endfunction

   task automatic chk_addr(input string req, input int r, input int c, input int ch);
      chk(int'(row_idx) == r, req, "row_idx", row_idx, r);
      chk(int'(col_idx) == c, req, "col_idx", col_idx, c);
      chk(int'(challenge) == ch, req, "challenge", challenge, ch);
   endtask

   task automatic chk_no_en(input string req);
      chk(row_en == '0, req, "row_en idle", row_en, 0);
      chk(col_en == '0, req, "col_en idle", col_en, 0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sweep_req == 1'b0, "R1", "sweep_req", sweep_req, 0);
      chk(scan_done == 1'b0, "R1", "scan_done", scan_done, 0);
      chk_no_en("R1");
      chk_addr("R1", 0, 0, 0);
      rst_n = 1'b1;

      // R10: sweep_done while idle is ignored
      @(negedge clk); sweep_done = 1'b1;
      @(negedge clk); sweep_done = 1'b0;
      repeat (2) begin
         @(negedge clk);
         chk(sweep_req == 1'b0, "R10", "sweep_req idle", sweep_req, 0);
         chk_no_en("R10");
      end

      start = 1'b1;
      @(negedge clk); start = 1'b0;

      for (int ch = 0; ch < NUM_CHAL; ch++) begin
         for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
               int sel, other, waits;
               sel = r * COLS + c;
               // launch cycle
               chk(sweep_req == 1'b1, "R3", "sweep_req launch", sweep_req, 1);
               chk_addr((c == 0 && r == 0) ? ((ch == 0) ? "R2" : "R7") : "R6", r, c, ch);
               chk(int'(row_en) == exp_en(r), "R4", "row_en", row_en, exp_en(r));
               chk(int'(col_en) == exp_en(c), "R4", "col_en", col_en, exp_en(c));
               chk(scan_done == 1'b0, "R8", "scan_done early", scan_done, 0);
               @(negedge clk);
               chk(sweep_req == 1'b0, "R3", "sweep_req width", sweep_req, 0);
               start = 1'b1;
               // R9 selected cell error passes
               cell_err = CELLS'(1) << sel;
               #1 chk(err_any == 1'b1, "R9", "err selected", err_any, 1);
               other = (sel + 1 + int'($urandom_range(0, CELLS - 2))) % CELLS;
               cell_err = CELLS'(1) << other;
               #1 chk(err_any == 1'b0, "R9", "err unselected", err_any, 0);
               cell_err = CELLS'($urandom) & ~(CELLS'(1) << sel);
               #1 chk(err_any == 1'b0, "R9", "err random others", err_any, 0);
               cell_err = '0;
               waits = int'($urandom_range(0, 3));
               for (int w = 0; w < waits; w++) begin
                  @(negedge clk);
                  chk(sweep_req == 1'b0, "R10", "start while busy", sweep_req, 0);
                  chk_addr("R5", r, c, ch);
               end
               start = 1'b0;
               sweep_done = 1'b1;
               @(negedge clk);
               sweep_done = 1'b0;
               chk(sweep_req == 1'b0, "R6", "no req in step", sweep_req, 0);
               chk_no_en("R4");
               @(negedge clk);
            end
         end
      end

      // R8 finished
      chk(scan_done == 1'b1, "R8", "scan_done", scan_done, 1);
      chk(sweep_req == 1'b0, "R8", "sweep_req after end", sweep_req, 0);
      chk_no_en("R8");
      for (int k = 0; k < 3; k++) begin
         sweep_done = 1'b1;
         @(negedge clk);
         sweep_done = 1'b0;
         chk(scan_done == 1'b1, "R8", "scan_done held", scan_done, 1);
         chk(sweep_req == 1'b0, "R10", "sweep_done in done", sweep_req, 0);
      end

      // R11 restart
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(sweep_req == 1'b1, "R11", "restart req", sweep_req, 1);
      chk(scan_done == 1'b0, "R11", "scan_done cleared", scan_done, 0);
      chk_addr("R11", 0, 0, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule